// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a VCO-rate clock down to the comparison rate of a frequency synthesizer. A digital model of a dual-modulus prescaler divides by P or P+1. Two counters sit behind it. The swallow counter holds the prescaler in its P+1 mode for the first A prescaler periods of each division cycle. The main counter ends the cycle after B prescaler periods. Each cycle therefore spans P×B+A VCO clocks, and P is 64 or 128.

A new swallow value, main value or modulus choice is captured only when a cycle ends, or while reset is held. A value written partway through a cycle has no effect on that cycle. The block also raises a combinational flag when the presented setting cannot give a correct ratio.

Top module: `pswallow_divider`

## Requirements
- R1: Once reset is released, consecutive divided pulses are exactly P×B+A clocks apart, and the first cycle after reset has the same length.
- R2: Within each cycle, `modCtrl` is high for exactly the first A×(P+1) clocks and low for the rest. With A=B it stays high for the whole cycle.
- R3: When A=0, `modCtrl` stays low for the whole cycle, so every prescaler period lasts P clocks.
- R4: `modSel`=1 selects P=64 (64/65 pair). `modSel`=0 selects P=128 (128/129 pair).
- R5: `divPulse` is high for exactly one clock per division cycle.
- R6: `swallowCount`, `progCount` and `modSel` are captured only on the clock edge that ends a cycle, or on an edge with reset high. A change made mid-cycle leaves the length of the running cycle unchanged and applies from the next cycle.
- R7: `cfgErr` is high, combinationally from the present inputs, when `progCount` < 3 or `swallowCount` > `progCount`. It is low otherwise.
- R8: `rst` is synchronous and active high. While it is held, `divPulse` is low and `modCtrl` equals (`swallowCount`≠0). After release, the first `divPulse` is high in the period after the (P×B+A−1)-th rising edge at which `rst` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | VCO-rate clock |
| rst | input | 1 | Synchronous active-high reset; also loads the setting |
| swallowCount | input | 7 | Swallow preset A (0..127) |
| progCount | input | 11 | Main preset B (3..2047) |
| modSel | input | 1 | 1: P=64, 0: P=128 |
| divPulse | output | 1 | One-clock pulse per division cycle |
| modCtrl | output | 1 | High while the prescaler divides by P+1 |
| cfgErr | output | 1 | Illegal setting flag (B<3 or A>B) |

## Verification
The bench measures whole cycles for both moduli. A counter that used a single terminal count, or that took the wrong P, would give the wrong spacing between pulses.

It counts how many clocks `modCtrl` is high in a cycle. This catches a swallow phase that is off by one prescaler period, that leaks into the A=0 case, or that drops the last period when A equals B.

A setting changed ten clocks into a cycle must not shorten that cycle. A design that loaded the setting at once would show a wrong interval there.

The first pulse after reset and the width of each pulse are also checked. These catch an extra reload stage and a pulse stretched over two clocks.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;

  // Strobes sent from control to datapath each clock
  typedef struct packed {
    logic preTerm;   // prescaler period ends this clock
    logic cycleEnd;  // whole division cycle ends this clock
    logic load;      // capture a new setting on the next edge
  } divStrobe_t;

endpackage

// File: rtl/pswallow_datapath.sv
module pswallow_datapath
  import pswallow_pkg::*;
#(
  parameter int SWALLOW_W = 7,
  parameter int PROG_W    = 11,
  parameter int MOD_LO    = 64,
  parameter int MOD_HI    = 128,
  parameter int PRE_W     = $clog2(MOD_HI + 1)
) (
  input  logic                 clk,
  input  divStrobe_t           strb,
  input  logic [SWALLOW_W-1:0] aIn,
  input  logic [PROG_W-1:0]    bIn,
  input  logic                 selIn,
  output logic                 preZero,
  output logic                 bLast,
  output logic                 modCtrl
);

  localparam logic [PRE_W-1:0] LO_M1 = PRE_W'(MOD_LO - 1);
  localparam logic [PRE_W-1:0] HI_M1 = PRE_W'(MOD_HI - 1);

  logic [PRE_W-1:0]     preCnt;
  logic [SWALLOW_W-1:0] aRem;
  logic [PROG_W-1:0]    bRem;
  logic                 actSel;

  logic [SWALLOW_W-1:0] aDec;
  logic                 aInNz;
  logic                 aDecNz;
  logic [PRE_W-1:0]     loadPre;
  logic [PRE_W-1:0]     nextPre;

  always_comb begin
    aInNz   = (aIn != '0);
    aDec    = (aRem != '0) ? aRem - SWALLOW_W'(1) : '0;
    aDecNz  = (aDec != '0);
    loadPre = (selIn  ? LO_M1 : HI_M1) + PRE_W'(aInNz);
    nextPre = (actSel ? LO_M1 : HI_M1) + PRE_W'(aDecNz);
  end

  always_ff @(posedge clk) begin
    if (strb.load) begin
      aRem   <= aIn;
      bRem   <= bIn;
      actSel <= selIn;
      preCnt <= loadPre;
    end else if (strb.preTerm) begin
      aRem   <= aDec;
      bRem   <= bRem - PROG_W'(1);
      preCnt <= nextPre;
    end else begin
      preCnt <= preCnt - PRE_W'(1);
    end
  end

  assign preZero = (preCnt == '0);
  assign bLast   = (bRem == PROG_W'(1));
  assign modCtrl = (aRem != '0);

endmodule

// File: rtl/pswallow_ctrl.sv
module pswallow_ctrl
  import pswallow_pkg::*;
(
  input  logic       rst,
  input  logic       preZero,
  input  logic       bLast,
  output divStrobe_t strb,
  output logic       divPulse
);

  always_comb begin
    strb.preTerm  = preZero;
    strb.cycleEnd = preZero && bLast;
    strb.load     = rst || strb.cycleEnd;
    divPulse      = !rst && strb.cycleEnd;
  end

endmodule

// File: rtl/pswallow_cfgcheck.sv
module pswallow_cfgcheck #(
  parameter int SWALLOW_W = 7,
  parameter int PROG_W    = 11,
  parameter int PROG_MIN  = 3
) (
  input  logic [SWALLOW_W-1:0] aIn,
  input  logic [PROG_W-1:0]    bIn,
  output logic                 cfgErr
);

  always_comb begin
    cfgErr = (bIn < PROG_W'(PROG_MIN)) || (PROG_W'(aIn) > bIn);
  end

endmodule

// File: rtl/pswallow_divider.sv
module pswallow_divider
  import pswallow_pkg::*;
#(
  parameter int SWALLOW_W = 7,
  parameter int PROG_W    = 11,
  parameter int MOD_LO    = 64,
  parameter int MOD_HI    = 128,
  parameter int PROG_MIN  = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SWALLOW_W-1:0] swallowCount,
  input  logic [PROG_W-1:0]    progCount,
  input  logic                 modSel,
  output logic                 divPulse,
  output logic                 modCtrl,
  output logic                 cfgErr
);

  localparam int PRE_W = $clog2(MOD_HI + 1);

  divStrobe_t strb;
  logic       preZero;
  logic       bLast;

  pswallow_ctrl u_ctrl (
    .rst      (rst),
    .preZero  (preZero),
    .bLast    (bLast),
    .strb     (strb),
    .divPulse (divPulse)
  );

  pswallow_datapath #(
    .SWALLOW_W (SWALLOW_W),
    .PROG_W    (PROG_W),
    .MOD_LO    (MOD_LO),
    .MOD_HI    (MOD_HI),
    .PRE_W     (PRE_W)
  ) u_dp (
    .clk     (clk),
    .strb    (strb),
    .aIn     (swallowCount),
    .bIn     (progCount),
    .selIn   (modSel),
    .preZero (preZero),
    .bLast   (bLast),
    .modCtrl (modCtrl)
  );

  pswallow_cfgcheck #(
    .SWALLOW_W (SWALLOW_W),
    .PROG_W    (PROG_W),
    .PROG_MIN  (PROG_MIN)
  ) u_cfg (
    .aIn    (swallowCount),
    .bIn    (progCount),
    .cfgErr (cfgErr)
  );

endmodule

// File: rtl/pswallow_chk.sv
module pswallow_chk #(
  parameter int SWALLOW_W = 7,
  parameter int PROG_W    = 11,
  parameter int MOD_LO    = 64,
  parameter int MOD_HI    = 128,
  parameter int PROG_MIN  = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic [SWALLOW_W-1:0] swallowCount,
  input logic [PROG_W-1:0]    progCount,
  input logic                 modSel,
  input logic                 divPulse,
  input logic                 modCtrl
);

  localparam int CNT_W = $clog2((MOD_HI + 1) * (2 ** PROG_W)) + 2;

  logic [CNT_W-1:0] curP, liveN, liveHi;
  logic [CNT_W-1:0] stCnt, hiCnt, expN, expHi;
  logic             latOk, aNz;

  always_comb begin
    curP   = modSel ? CNT_W'(MOD_LO) : CNT_W'(MOD_HI);
    liveN  = curP * CNT_W'(progCount) + CNT_W'(swallowCount);
    liveHi = (curP + CNT_W'(1)) * CNT_W'(swallowCount);
  end

  always_ff @(posedge clk) begin
    if (rst || divPulse) begin
      stCnt <= '0;
      hiCnt <= '0;
      expN  <= liveN;
      expHi <= liveHi;
      latOk <= (progCount >= PROG_W'(PROG_MIN)) && (PROG_W'(swallowCount) <= progCount);
      aNz   <= (swallowCount != '0);
    end else begin
      stCnt <= stCnt + CNT_W'(1);
      hiCnt <= hiCnt + CNT_W'(modCtrl);
    end
  end

  // R1
  period_len_chk: assert property (@(posedge clk) disable iff (rst)
    (divPulse && latOk) |-> (stCnt + CNT_W'(1) == expN));

  // R2
  swallow_span_chk: assert property (@(posedge clk) disable iff (rst)
    (divPulse && latOk) |-> (hiCnt + CNT_W'(modCtrl) == expHi));

  // R2
  mod_stays_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!modCtrl && !divPulse) |=> !modCtrl);

  // R3
  mod_start_chk: assert property (@(posedge clk) disable iff (rst)
    $past(divPulse) |-> (modCtrl == aNz));

  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    divPulse |=> !divPulse);

endmodule

bind pswallow_divider pswallow_chk #(
  .SWALLOW_W (SWALLOW_W),
  .PROG_W    (PROG_W),
  .MOD_LO    (MOD_LO),
  .MOD_HI    (MOD_HI),
  .PROG_MIN  (PROG_MIN)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .swallowCount (swallowCount),
  .progCount    (progCount),
  .modSel       (modSel),
  .divPulse     (divPulse),
  .modCtrl      (modCtrl)
);

// File: tb/pswallow_divider_tb.sv
module pswallow_divider_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 60000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  swallowCount = '0;
  logic [10:0] progCount = 11'd10;
  logic        modSel = 1'b1;
  logic        divPulse, modCtrl, cfgErr;

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  pswallow_divider u_dut (
    .clk (clk), .rst (rst), .swallowCount (swallowCount), .progCount (progCount),
    .modSel (modSel), .divPulse (divPulse), .modCtrl (modCtrl), .cfgErr (cfgErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      finishRun();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int modOf(input bit sel);
    return sel ? 64 : 128;
  endfunction

  // Count negedges until divPulse is seen high
  task automatic waitPulse(output int cnt);
    cnt = 0;
    for (int i = 0; i < LIMIT; i++) begin
      @(negedge clk);
      cnt++;
      if (divPulse) break;
    end
  endtask

  // Starting at a pulse negedge: length of the next cycle and its modCtrl-high clocks
  task automatic measure(output int n, output int hi, output bit wide);
    n = 0; hi = 0; wide = 1'b0;
    for (int i = 0; i < LIMIT; i++) begin
      @(negedge clk);
      n++;
      if (modCtrl) hi++;
      if (divPulse) begin
        if (n == 1) wide = 1'b1;
        else break;
      end
    end
  endtask

  task automatic doReset(input int a, input int b, input bit sel);
    @(negedge clk);
    rst = 1'b1;
    swallowCount = 7'(a); progCount = 11'(b); modSel = sel;
    repeat (3) @(negedge clk);
    check(divPulse == 1'b0, "R8 pulse low in reset", int'(divPulse), 0);
    check(modCtrl == (a != 0), "R8 modCtrl in reset", int'(modCtrl), int'(a != 0));
    rst = 1'b0;
  endtask

  // R8 and R1: first pulse timing after reset
  task automatic testFirstPulse(input int a, input int b, input bit sel);
    int cnt;
    int expN;
    expN = modOf(sel) * b + a;
    doReset(a, b, sel);
    waitPulse(cnt);
    check(cnt == expN - 1, "R8 first pulse", cnt, expN - 1);
  endtask

  // R1 R2 R3 R4 R5: steady cycles for one setting
  task automatic testCycles(input int a, input int b, input bit sel, input string tag);
    int cnt, n, hi, expN, expHi;
    bit wide;
    expN  = modOf(sel) * b + a;
    expHi = a * (modOf(sel) + 1);
    doReset(a, b, sel);
    waitPulse(cnt);
    for (int k = 0; k < 2; k++) begin
      measure(n, hi, wide);
      check(n == expN, {"R1 R4 period ", tag}, n, expN);
      check(hi == expHi, {"R2 R3 swallow span ", tag}, hi, expHi);
      check(!wide, {"R5 pulse width ", tag}, int'(wide), 0);
    end
  endtask

  // R6: mid-cycle change applies to the next cycle only
  task automatic testMidChange();
    int cnt, n, hi, nx, ny;
    bit wide;
    nx = 64 * 10 + 5;
    ny = 128 * 4 + 2;
    doReset(5, 10, 1'b1);
    waitPulse(cnt);
    repeat (10) @(negedge clk);
    swallowCount = 7'd2; progCount = 11'd4; modSel = 1'b0;
    waitPulse(cnt);
    check(cnt + 10 == nx, "R6 running cycle kept", cnt + 10, nx);
    measure(n, hi, wide);
    check(n == ny, "R6 new setting applied", n, ny);
    check(hi == 2 * 129, "R6 new swallow span", hi, 2 * 129);
  endtask

  // R7: configuration error flag
  task automatic testCfg();
    @(negedge clk);
    rst = 1'b1;
    swallowCount = 7'd0; progCount = 11'd2; #1;
    check(cfgErr == 1'b1, "R7 B below 3", int'(cfgErr), 1);
    swallowCount = 7'd9; progCount = 11'd8; #1;
    check(cfgErr == 1'b1, "R7 A above B", int'(cfgErr), 1);
    swallowCount = 7'd8; progCount = 11'd8; #1;
    check(cfgErr == 1'b0, "R7 A equals B", int'(cfgErr), 0);
    swallowCount = 7'd0; progCount = 11'd3; #1;
    check(cfgErr == 1'b0, "R7 B at minimum", int'(cfgErr), 0);
    swallowCount = 7'd127; progCount = 11'd2047; #1;
    check(cfgErr == 1'b0, "R7 top values", int'(cfgErr), 0);
  endtask

  initial begin
    testCfg();
    testFirstPulse(5, 10, 1'b1);
    testFirstPulse(20, 40, 1'b0);
    testCycles(5, 10, 1'b1, "a5 b10 p64");
    testCycles(0, 7, 1'b0, "a0 b7 p128");
    testCycles(3, 3, 1'b1, "a3 b3 p64");
    testCycles(20, 40, 1'b0, "a20 b40 p128");
    testMidChange();
    finishRun();
  end

endmodule